// File: doc/BRIEF.md
# Ordered Release Store-Pair Issue Unit

This unit takes one 32-bit instruction word for a release-ordered store of two registers. It decodes the word and reads the base register and the two data registers through combinational read ports. It then forms the target address, which is either the base itself or the base lowered by the size of the pair. The two elements go out as two separate beats on a valid/ready memory-write channel. When the addressing mode calls for it, the lowered base is written back once the second beat has been taken.

The order of the two beats depends on the mode. In pre-decrement mode the beat for the second data register leads. In plain-base mode the beat for the first data register leads. Where each register lands in memory (lower or upper element) depends only on the endianness input. Words that do not decode, and stack-pointer bases that are not 16-byte aligned, end with a single-cycle flag and nothing is issued.

Top module: `pair_store_issue`

## Requirements
- R1: A word is accepted as legal only when bit 31=1, bits 29:23=0110010, bits 22 and 21 are 0, bits 15:13=000 and bits 11:10=10. Any other word raises `undef` for exactly the one cycle after acceptance, with no beat, no writeback and no `done`.
- R2: Bit 30 sets the element width: 0 means 32-bit elements (pair of 8 bytes) and 1 means 64-bit elements (pair of 16 bytes). A 32-bit beat carries the low 32 register bits zero-extended with `mw_strb`=8'h0F. A 64-bit beat carries all 64 bits with `mw_strb`=8'hFF.
- R3: Bit 12=0 selects pre-decrement mode, where the target is base minus the pair size. Bit 12=1 selects plain-base mode, where the target is the base. The lower element sits at the target and the upper element at target plus the element size.
- R4: With `big_endian`=0 the first data register (bits 4:0) fills the lower element and the second (bits 20:16) fills the upper element. With `big_endian`=1 the two are swapped.
- R5: In pre-decrement mode the beat for the second data register is issued first. In plain-base mode the beat for the first data register is issued first.
- R6: A base field (bits 9:5) of 31 selects `sp_val` as the base. In that case, if `sp_val[3:0]` is nonzero, `align_fault` pulses for the one cycle after acceptance and no beat or writeback follows.
- R7: `mw_tagchk` is 1 on both beats when the mode is pre-decrement or the base field is not 31, and 0 otherwise.
- R8: A data register field of 31 stores zero, whatever the read port returns.
- R9: In pre-decrement mode, when a data field equals a base field other than 31, the stored value is the register value before writeback and no fault is raised.
- R10: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr`, `mw_data`, `mw_strb` and `mw_tagchk` stay unchanged.
- R11: `done` pulses in the cycle after the second beat is accepted. In pre-decrement mode `wb_valid` pulses in that same cycle, carrying the target address, the base index and `wb_to_sp`=1 when the base field is 31. In plain-base mode there is no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction word offered |
| cmd_ready | output | 1 | Unit is idle and takes the word |
| cmd_word | input | 32 | Instruction word |
| big_endian | input | 1 | Data endianness for this access |
| rs_base_idx | output | 5 | Base register read index |
| rs_base_val | input | 64 | Base register read data |
| rs_a_idx | output | 5 | First data register read index |
| rs_a_val | input | 64 | First data register read data |
| rs_b_idx | output | 5 | Second data register read index |
| rs_b_val | input | 64 | Second data register read data |
| sp_val | input | 64 | Current stack pointer |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory write beat taken |
| mw_addr | output | 64 | Beat byte address |
| mw_data | output | 64 | Beat element data |
| mw_strb | output | 8 | Beat byte strobes |
| mw_tagchk | output | 1 | Access is tag-checked |
| wb_valid | output | 1 | Base writeback strobe |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_val | output | 64 | Writeback value |
| done | output | 1 | Instruction completed |
| undef | output | 1 | Illegal encoding pulse |
| align_fault | output | 1 | Stack pointer alignment fault pulse |

## Verification
Every result falls in a fixed cycle relative to acceptance. The `undef` and `align_fault` pulses, and the first beat, appear in the cycle right after the accepting edge. Each later beat appears in the cycle after the previous beat's handshake, and `done` and `wb_valid` appear in the cycle after the second handshake. The bench drives and samples on the falling edge. Its behavioural model keeps a queue of expected beats and compares the channel in every cycle it walks through, including each stalled cycle, so an early or late output shows up as a miscompare in that same cycle.

// File: rtl/psi_pkg.sv
package psi_pkg;
  localparam int XLEN   = 64;
  localparam int IDX_W  = 5;
  localparam int STRB_W = XLEN / 8;
  localparam int HALF   = XLEN / 2;
  localparam logic [IDX_W-1:0] SP_IDX = '1;
  localparam int SP_ALIGN_BITS = 4;

  typedef struct packed {
    logic [XLEN-1:0]   addr;
    logic [XLEN-1:0]   data;
    logic [STRB_W-1:0] strb;
  } beat_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SEND0  = 2'd1,
    S_SEND1  = 2'd2,
    S_FINISH = 2'd3
  } seq_state_t;

  // bytes covered by both elements
  function automatic logic [XLEN-1:0] pair_span(input logic wide);
    pair_span = wide ? XLEN'(2 * STRB_W) : XLEN'(STRB_W);
  endfunction

  // bytes covered by one element
  function automatic logic [XLEN-1:0] elem_span(input logic wide);
    elem_span = wide ? XLEN'(STRB_W) : XLEN'(STRB_W / 2);
  endfunction

  // register value as it appears on the lane, zero register honoured
  function automatic logic [XLEN-1:0] lane_value(input logic [XLEN-1:0] v,
                                                 input logic [IDX_W-1:0] idx,
                                                 input logic wide);
    logic [XLEN-1:0] r;
    r = (idx == SP_IDX) ? '0 : v;
    if (!wide) r = {{HALF{1'b0}}, r[HALF-1:0]};
    lane_value = r;
  endfunction

  function automatic logic [STRB_W-1:0] lane_strb(input logic wide);
    lane_strb = wide ? '1 : {{(STRB_W/2){1'b0}}, {(STRB_W/2){1'b1}}};
  endfunction
endpackage

// File: rtl/psi_decode.sv
module psi_decode
  import psi_pkg::*;
(
  input  logic [31:0]      word,
  output logic             legal,
  output logic             wide,
  output logic             pre,
  output logic [IDX_W-1:0] rt,
  output logic [IDX_W-1:0] rt2,
  output logic [IDX_W-1:0] rn
);
  logic fixed_hi_ok;
  logic fixed_mid_ok;
  logic fixed_lo_ok;

  assign fixed_hi_ok  = word[31] && (word[29:23] == 7'b0110010) && !word[22] && !word[21];
  assign fixed_mid_ok = (word[15:13] == 3'b000);
  assign fixed_lo_ok  = (word[11:10] == 2'b10);

  assign legal = fixed_hi_ok && fixed_mid_ok && fixed_lo_ok;
  assign wide  = word[30];
  assign pre   = !word[12];
  assign rt2   = word[20:16];
  assign rn    = word[9:5];
  assign rt    = word[4:0];
endmodule

// File: rtl/psi_addr_gen.sv
module psi_addr_gen
  import psi_pkg::*;
(
  input  logic             wide,
  input  logic             pre,
  input  logic             big_endian,
  input  logic [IDX_W-1:0] rt,
  input  logic [IDX_W-1:0] rt2,
  input  logic [IDX_W-1:0] rn,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  sp_val,
  input  logic [XLEN-1:0]  a_val,
  input  logic [XLEN-1:0]  b_val,
  output beat_t            first,
  output beat_t            second,
  output logic             tagchk,
  output logic             misaligned,
  output logic [XLEN-1:0]  new_base
);
  logic            use_sp;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] lo_addr;
  logic [XLEN-1:0] hi_addr;
  beat_t           a_beat;
  beat_t           b_beat;

  assign use_sp     = (rn == SP_IDX);
  assign base       = use_sp ? sp_val : base_val;
  assign lo_addr    = pre ? (base - pair_span(wide)) : base;
  assign hi_addr    = lo_addr + elem_span(wide);
  assign new_base   = lo_addr;
  assign misaligned = use_sp && (sp_val[SP_ALIGN_BITS-1:0] != '0);
  assign tagchk     = pre || !use_sp;

  // element placement follows endianness only
  always_comb begin
    a_beat.data = lane_value(a_val, rt, wide);
    b_beat.data = lane_value(b_val, rt2, wide);
    a_beat.strb = lane_strb(wide);
    b_beat.strb = lane_strb(wide);
    a_beat.addr = big_endian ? hi_addr : lo_addr;
    b_beat.addr = big_endian ? lo_addr : hi_addr;
  end

  // issue order follows the addressing mode only
  assign first  = pre ? b_beat : a_beat;
  assign second = pre ? a_beat : b_beat;
endmodule

// File: rtl/psi_beat_seq.sv
module psi_beat_seq
  import psi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             legal,
  input  logic             misaligned,
  input  logic             pre,
  input  logic [IDX_W-1:0] rn,
  input  beat_t            first,
  input  beat_t            second,
  input  logic             tagchk,
  input  logic [XLEN-1:0]  new_base,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [XLEN-1:0]  mw_addr,
  output logic [XLEN-1:0]  mw_data,
  output logic [STRB_W-1:0] mw_strb,
  output logic             mw_tagchk,
  output logic             wb_valid,
  output logic             wb_to_sp,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_val,
  output logic             done,
  output logic             undef,
  output logic             align_fault
);
  seq_state_t       state_q;
  beat_t            beat_q [2];
  logic             tag_q;
  logic             pre_q;
  logic [IDX_W-1:0] rn_q;
  logic [XLEN-1:0]  nb_q;
  logic             undef_q;
  logic             fault_q;

  logic accept;
  logic start_ok;
  logic first_taken;
  logic second_taken;
  beat_t cur;

  assign cmd_ready    = (state_q == S_IDLE);
  assign accept       = cmd_valid && cmd_ready;
  assign start_ok     = accept && legal && !misaligned;
  assign first_taken  = (state_q == S_SEND0) && mw_ready;
  assign second_taken = (state_q == S_SEND1) && mw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      tag_q   <= 1'b0;
      pre_q   <= 1'b0;
      rn_q    <= '0;
      nb_q    <= '0;
      beat_q[0] <= '0;
      beat_q[1] <= '0;
    end else begin
      undef_q <= accept && !legal;
      fault_q <= accept && legal && misaligned;
      if (start_ok) begin
        beat_q[0] <= first;
        beat_q[1] <= second;
        tag_q     <= tagchk;
        pre_q     <= pre;
        rn_q      <= rn;
        nb_q      <= new_base;
      end
      unique case (state_q)
        S_IDLE:   if (start_ok) state_q <= S_SEND0;
        S_SEND0:  if (first_taken) state_q <= S_SEND1;
        S_SEND1:  if (second_taken) state_q <= S_FINISH;
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign cur         = (state_q == S_SEND1) ? beat_q[1] : beat_q[0];
  assign mw_valid    = (state_q == S_SEND0) || (state_q == S_SEND1);
  assign mw_addr     = cur.addr;
  assign mw_data     = cur.data;
  assign mw_strb     = cur.strb;
  assign mw_tagchk   = tag_q;
  assign done        = (state_q == S_FINISH);
  assign wb_valid    = done && pre_q;
  assign wb_to_sp    = (rn_q == SP_IDX);
  assign wb_idx      = rn_q;
  assign wb_val      = nb_q;
  assign undef       = undef_q;
  assign align_fault = fault_q;

  // R10: a stalled beat keeps every field
  p_hold_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)
                                 && $stable(mw_strb) && $stable(mw_tagchk)));

  // R11: completion only follows acceptance of the second beat
  p_done_after_second_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(second_taken));

  // R11: writeback never outside a completion
  p_wb_in_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  // R1: illegal word leaves the channel idle
  p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!mw_valid && !done));

  // R6: a fault leaves the channel idle
  p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (!mw_valid && !wb_valid));

  p_events_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undef, align_fault}));
endmodule

// File: rtl/pair_store_issue.sv
module pair_store_issue
  import psi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_word,
  input  logic        big_endian,
  output logic [4:0]  rs_base_idx,
  input  logic [63:0] rs_base_val,
  output logic [4:0]  rs_a_idx,
  input  logic [63:0] rs_a_val,
  output logic [4:0]  rs_b_idx,
  input  logic [63:0] rs_b_val,
  input  logic [63:0] sp_val,
  output logic        mw_valid,
  input  logic        mw_ready,
  output logic [63:0] mw_addr,
  output logic [63:0] mw_data,
  output logic [7:0]  mw_strb,
  output logic        mw_tagchk,
  output logic        wb_valid,
  output logic        wb_to_sp,
  output logic [4:0]  wb_idx,
  output logic [63:0] wb_val,
  output logic        done,
  output logic        undef,
  output logic        align_fault
);
  logic             legal;
  logic             wide;
  logic             pre;
  logic [IDX_W-1:0] rt;
  logic [IDX_W-1:0] rt2;
  logic [IDX_W-1:0] rn;
  beat_t            first;
  beat_t            second;
  logic             tagchk;
  logic             misaligned;
  logic [XLEN-1:0]  new_base;

  psi_decode u_decode (
    .word  (cmd_word),
    .legal (legal),
    .wide  (wide),
    .pre   (pre),
    .rt    (rt),
    .rt2   (rt2),
    .rn    (rn)
  );

  assign rs_base_idx = rn;
  assign rs_a_idx    = rt;
  assign rs_b_idx    = rt2;

  psi_addr_gen u_addr (
    .wide       (wide),
    .pre        (pre),
    .big_endian (big_endian),
    .rt         (rt),
    .rt2        (rt2),
    .rn         (rn),
    .base_val   (rs_base_val),
    .sp_val     (sp_val),
    .a_val      (rs_a_val),
    .b_val      (rs_b_val),
    .first      (first),
    .second     (second),
    .tagchk     (tagchk),
    .misaligned (misaligned),
    .new_base   (new_base)
  );

  psi_beat_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .legal       (legal),
    .misaligned  (misaligned),
    .pre         (pre),
    .rn          (rn),
    .first       (first),
    .second      (second),
    .tagchk      (tagchk),
    .new_base    (new_base),
    .mw_valid    (mw_valid),
    .mw_ready    (mw_ready),
    .mw_addr     (mw_addr),
    .mw_data     (mw_data),
    .mw_strb     (mw_strb),
    .mw_tagchk   (mw_tagchk),
    .wb_valid    (wb_valid),
    .wb_to_sp    (wb_to_sp),
    .wb_idx      (wb_idx),
    .wb_val      (wb_val),
    .done        (done),
    .undef       (undef),
    .align_fault (align_fault)
  );

  // R6: misaligned stack base at acceptance yields the fault pulse next cycle
  p_sp_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && legal && (rn == SP_IDX) && (sp_val[3:0] != 4'd0))
      |=> align_fault);

  // R1: a word failing the fixed fields never starts a beat
  p_illegal_no_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_word[11:10] != 2'b10)) |=> (undef && !mw_valid));
endmodule

// File: tb/pair_store_issue_bench.sv
module pair_store_issue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        big_endian = 1'b0;
  logic [4:0]  rs_base_idx, rs_a_idx, rs_b_idx;
  logic [63:0] rs_base_val, rs_a_val, rs_b_val;
  logic [63:0] sp_val = '0;
  logic        mw_valid;
  logic        mw_ready = 1'b0;
  logic [63:0] mw_addr, mw_data;
  logic [7:0]  mw_strb;
  logic        mw_tagchk;
  logic        wb_valid, wb_to_sp;
  logic [4:0]  wb_idx;
  logic [63:0] wb_val;
  logic        done, undef, align_fault;

  logic [63:0] xr [32];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rs_base_val = xr[rs_base_idx];
  assign rs_a_val    = xr[rs_a_idx];
  assign rs_b_val    = xr[rs_b_idx];

  pair_store_issue u_pair_store_issue (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .big_endian(big_endian),
    .rs_base_idx(rs_base_idx), .rs_base_val(rs_base_val),
    .rs_a_idx(rs_a_idx), .rs_a_val(rs_a_val),
    .rs_b_idx(rs_b_idx), .rs_b_val(rs_b_val), .sp_val(sp_val),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_strb(mw_strb), .mw_tagchk(mw_tagchk),
    .wb_valid(wb_valid), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx), .wb_val(wb_val),
    .done(done), .undef(undef), .align_fault(align_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input bit w64, input bit plain,
                                     input int b, input int n, input int a);
    mk = {1'b1, w64, 7'b0110010, 2'b00, 5'(b), 3'b000, plain, 2'b10, 5'(n), 5'(a)};
  endfunction

  // reference model: returns expected beat queue and outcome
  task automatic run(input logic [31:0] w, input bit be, input int st0, input int st1,
                     input string tag);
    logic [63:0] q_addr[$], q_data[$];
    logic [7:0]  q_strb[$];
    int n, a, b, esz, slot_a;
    bit ok, w64, pre, tagx, misal;
    logic [63:0] basev, tgt, va, vb;
    n = int'(w[9:5]); a = int'(w[4:0]); b = int'(w[20:16]);
    ok = (w[31] == 1'b1) && (w[29:23] == 7'h32) && (w[22:21] == 2'b00)
         && (w[15:13] == 3'b000) && (w[11:10] == 2'b10);
    w64 = w[30]; pre = (w[12] == 1'b0);
    esz = w64 ? 8 : 4;
    basev = (n == 31) ? sp_val : xr[n];
    misal = (n == 31) && ((sp_val % 16) != 0);
    tgt = pre ? basev - 64'(2 * esz) : basev;
    tagx = pre || (n != 31);
    va = (a == 31) ? 64'd0 : xr[a];
    vb = (b == 31) ? 64'd0 : xr[b];
    if (!w64) begin va = va & 64'hFFFF_FFFF; vb = vb & 64'hFFFF_FFFF; end
    slot_a = be ? 1 : 0;
    if (pre) begin
      q_addr.push_back(tgt + 64'((1 - slot_a) * esz)); q_data.push_back(vb);
      q_addr.push_back(tgt + 64'(slot_a * esz));       q_data.push_back(va);
    end else begin
      q_addr.push_back(tgt + 64'(slot_a * esz));       q_data.push_back(va);
      q_addr.push_back(tgt + 64'((1 - slot_a) * esz)); q_data.push_back(vb);
    end
    q_strb.push_back(w64 ? 8'hFF : 8'h0F);
    q_strb.push_back(w64 ? 8'hFF : 8'h0F);

    @(negedge clk);
    chk(cmd_ready == 1'b1, {tag, " R11 ready idle"}, 64'(cmd_ready), 64'd1);
    cmd_word = w; big_endian = be; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!ok) begin
      chk(undef == 1'b1 && mw_valid == 1'b0, {tag, " R1 undef pulse"},
          64'({undef, mw_valid}), 64'b10);
      @(negedge clk);
      chk(undef == 1'b0 && mw_valid == 1'b0 && done == 1'b0, {tag, " R1 one cycle"},
          64'({undef, mw_valid, done}), 64'd0);
      return;
    end
    if (misal) begin
      chk(align_fault == 1'b1 && mw_valid == 1'b0, {tag, " R6 fault pulse"},
          64'({align_fault, mw_valid}), 64'b10);
      @(negedge clk);
      chk(align_fault == 1'b0 && mw_valid == 1'b0 && wb_valid == 1'b0,
          {tag, " R6 nothing issued"}, 64'({align_fault, mw_valid, wb_valid}), 64'd0);
      return;
    end
    for (int k = 0; k < 2; k++) begin
      int st;
      st = (k == 0) ? st0 : st1;
      for (int s = 0; s <= st; s++) begin
        mw_ready = (s == st);
        chk(mw_valid == 1'b1, {tag, " R10 valid held"}, 64'(mw_valid), 64'd1);
        chk(mw_addr == q_addr[k], {tag, " R3 R4 R5 beat addr"}, mw_addr, q_addr[k]);
        chk(mw_data == q_data[k], {tag, " R2 R8 R9 beat data"}, mw_data, q_data[k]);
        chk(mw_strb == q_strb[k], {tag, " R2 strobes"}, 64'(mw_strb), 64'(q_strb[k]));
        chk(mw_tagchk == tagx, {tag, " R7 tagchk"}, 64'(mw_tagchk), 64'(tagx));
        chk(done == 1'b0 && wb_valid == 1'b0, {tag, " R11 no early done"},
            64'({done, wb_valid}), 64'd0);
        @(negedge clk);
      end
    end
    mw_ready = 1'b0;
    chk(done == 1'b1 && mw_valid == 1'b0, {tag, " R11 done"}, 64'({done, mw_valid}), 64'b10);
    chk(wb_valid == pre, {tag, " R11 wb strobe"}, 64'(wb_valid), 64'(pre));
    if (pre) begin
      chk(wb_val == tgt, {tag, " R11 wb value"}, wb_val, tgt);
      chk(wb_idx == 5'(n) && wb_to_sp == (n == 31), {tag, " R11 wb target"},
          64'({wb_to_sp, wb_idx}), 64'({(n == 31), 5'(n)}));
    end
    @(negedge clk);
    chk(done == 1'b0 && wb_valid == 1'b0 && cmd_ready == 1'b1, {tag, " R11 back idle"},
        64'({done, wb_valid, cmd_ready}), 64'b001);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) xr[i] = 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_1111_0003);
    xr[3] = 64'h0000_0000_0000_1000;
    xr[7] = 64'h0000_0000_0000_2008;
    repeat (3) @(negedge clk);
    chk(mw_valid == 0 && done == 0 && undef == 0 && align_fault == 0 && wb_valid == 0,
        "reset R11 quiet", 64'({mw_valid, done, undef, align_fault, wb_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "reset R11 ready", 64'(cmd_ready), 64'd1);

    run(mk(0, 1, 5, 3, 4), 0, 0, 0, "w32 plain le R3 R5");
    run(mk(1, 0, 5, 3, 4), 0, 2, 1, "w64 pre le R5 R10");
    run(mk(0, 0, 9, 7, 10), 1, 1, 0, "w32 pre be R4");
    run(mk(1, 1, 9, 7, 10), 1, 0, 3, "w64 plain be R4");
    sp_val = 64'h0000_0000_0000_8000;
    run(mk(1, 0, 1, 31, 2), 0, 0, 0, "sp pre R6 R7");
    run(mk(0, 1, 1, 31, 2), 0, 1, 0, "sp plain R7");
    sp_val = 64'h0000_0000_0000_8008;
    run(mk(1, 1, 1, 31, 2), 0, 0, 0, "sp misaligned R6");
    run(mk(1, 0, 3, 3, 6), 0, 0, 0, "overlap R9");
    run(mk(1, 1, 31, 3, 31), 0, 0, 0, "zero reg R8");
    run(mk(1, 0, 5, 3, 4) | 32'h0020_0000, 0, 0, 0, "bit21 R1");
    run(mk(1, 0, 5, 3, 4) | 32'h0000_2000, 0, 0, 0, "opc bits R1");
    run(mk(1, 0, 5, 3, 4) & 32'h7FFF_FFFF, 0, 0, 0, "bit31 R1");
    run(mk(0, 0, 5, 3, 4), 0, 0, 0, "after undef R2");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule